// File: doc/BRIEF.md
# Byte-Serial Word Stack Engine

This block keeps a 16-bit stack pointer and moves 16-bit words between a requester and a byte-wide memory. A push request stores its word as two byte writes. A pop request reads two bytes and returns the joined word, marked by a one-cycle done pulse. The stack grows toward lower addresses. The pointer always holds the address of the entry on top of the stack, never the next free slot. Words are stored little-endian: the low byte sits at the pointer and the high byte at the pointer plus one.

The memory port is combinational on the read side. Read data must follow the address within the same cycle. A write is committed on the clock edge that ends a cycle in which the write strobe is high. After reset the pointer holds 0xFFFE, which marks an empty stack. A pop requested in that state raises an underflow pulse instead of touching memory. The stack pointer can be loaded directly while the engine is idle. The only access is to the top word; nothing can be read below it without popping.

Top module: `stack_engine`

## Requirements
- R1: After reset sp_o is 0xFFFE, and busy_o, done_o, underflow_o and mem_we_o are all 0.
- R2: A push accepted on an edge lowers sp_o by 2 at that edge. In the next cycle mem_we_o is 1 with mem_addr_o = new sp and mem_wdata_o = bits 7:0 of the word. In the cycle after that mem_we_o is 1 with mem_addr_o = new sp + 1 and mem_wdata_o = bits 15:8. In the third cycle done_o is 1 for one cycle.
- R3: A pop accepted on an edge drives mem_addr_o = sp in the next cycle and sp + 1 in the cycle after, with mem_we_o 0 in both. In the third cycle done_o is 1, pop_data_o = {byte read at sp+1, byte read at sp}, and sp_o has been raised by 2.
- R4: The pointer addresses the top entry, so pops return pushed words in reverse order of pushing.
- R5: A pop requested while sp_o is 0xFFFE causes no memory access and leaves sp_o unchanged. underflow_o is 1 in the following cycle only, and done_o stays 0.
- R6: While busy_o is 1, push_i, pop_i and sp_load_i are ignored.
- R7: If push_i and pop_i are both high while idle, the push is performed and the pop is dropped.
- R8: Pointer and address arithmetic wraps modulo 2^16.
- R9: sp_load_i while idle sets sp_o to sp_load_val_i at the next edge. It takes precedence over a push or pop requested in the same cycle, which is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push request |
| push_data_i | input | 16 | Word to push |
| pop_i | input | 1 | Pop request |
| sp_load_i | input | 1 | Load stack pointer |
| sp_load_val_i | input | 16 | Value for stack pointer load |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pop_data_o | output | 16 | Last popped word |
| underflow_o | output | 1 | Pop on empty stack, one-cycle pulse |
| sp_o | output | 16 | Current stack pointer |
| mem_addr_o | output | 16 | Memory byte address |
| mem_wdata_o | output | 8 | Memory write byte |
| mem_we_o | output | 1 | Memory write strobe |
| mem_rdata_i | input | 8 | Memory read byte, combinational |

## Verification
The hardest cases to reach are the address wrap and a request that arrives mid-operation. For the wrap, the pointer sits at 0x0001 or 0xFFFF and a word straddles 0xFFFF and 0x0000. For the mid-operation case, a pop or load arrives while a push is still writing its bytes. The stimulus reaches the wrap by loading the pointer directly before a push and a pop. It raises the competing requests during the two write cycles of a push, then checks that the pointer and the next operation are undisturbed. Random sequences of pushes, pops and loads to arbitrary (also odd) pointers follow. Each pop is checked against the bench's own byte memory.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LO, ST_HI, ST_DONE} stk_state_e;
endpackage

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int              AW       = 16,
  parameter logic [AW-1:0]   EMPTY_SP = 16'hFFFE,
  parameter int              STEP     = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [AW-1:0] ld_val_i,
  input  logic          dec_i,
  input  logic          inc_i,
  output logic [AW-1:0] sp_o,
  output logic          empty_o
);
  localparam logic [AW-1:0] STEP_W = AW'(STEP);

  logic [AW-1:0] sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sp_q <= EMPTY_SP;
    else if (ld_i)    sp_q <= ld_val_i;
    else if (dec_i)   sp_q <= sp_q - STEP_W;  // wraps mod 2^AW
    else if (inc_i)   sp_q <= sp_q + STEP_W;
  end

  assign sp_o    = sp_q;
  assign empty_o = (sp_q == EMPTY_SP);

  p_one_cmd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({ld_i, dec_i, inc_i}) <= 1);
endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       push_i,
  input  logic       pop_i,
  input  logic       load_i,
  input  logic       empty_i,
  output stk_state_e state_o,
  output logic       pop_op_o,
  output logic       ld_o,
  output logic       dec_o,
  output logic       inc_o,
  output logic       uflow_o
);
  stk_state_e state_q;
  logic       pop_q, uflow_q;
  logic       idle, start_pop;

  always_comb begin
    idle      = (state_q == ST_IDLE);
    ld_o      = idle & load_i;
    dec_o     = idle & ~load_i & push_i;
    start_pop = idle & ~load_i & ~push_i & pop_i;
    inc_o     = (state_q == ST_HI) & pop_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pop_q   <= 1'b0;
      uflow_q <= 1'b0;
    end else begin
      uflow_q <= start_pop & empty_i;
      unique case (state_q)
        ST_IDLE: if (dec_o || (start_pop && !empty_i)) begin
          state_q <= ST_LO;
          pop_q   <= start_pop;
        end
        ST_LO:   state_q <= ST_HI;
        ST_HI:   state_q <= ST_DONE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o  = state_q;
  assign pop_op_o = pop_q;
  assign uflow_o  = uflow_q;

  p_byte_order_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_LO |=> state_q == ST_HI);
  p_uflow_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uflow_q |-> state_q == ST_IDLE);
endmodule

// File: rtl/stk_dp.sv
module stk_dp
  import stk_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  stk_state_e      state_i,
  input  logic            pop_op_i,
  input  logic            start_push_i,
  input  logic [2*DW-1:0] push_data_i,
  input  logic [AW-1:0]   sp_i,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  output logic            mem_we_o,
  output logic [2*DW-1:0] pop_data_o
);
  localparam int WW = 2 * DW;

  logic [WW-1:0] word_q, pop_q;
  logic [DW-1:0] lo_q;
  logic          hi_phase;

  assign hi_phase    = (state_i == ST_HI);
  assign mem_addr_o  = sp_i + AW'(hi_phase);
  assign mem_wdata_o = hi_phase ? word_q[WW-1:DW] : word_q[DW-1:0];
  assign mem_we_o    = ~pop_op_i & ((state_i == ST_LO) | hi_phase);
  assign pop_data_o  = pop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      lo_q   <= '0;
      pop_q  <= '0;
    end else begin
      if (start_push_i) word_q <= push_data_i;
      if (pop_op_i && state_i == ST_LO) lo_q <= mem_rdata_i;
      if (pop_op_i && hi_phase) pop_q <= {mem_rdata_i, lo_q};
    end
  end

  p_hi_follows_lo_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_o) |=> mem_we_o && mem_addr_o == $past(mem_addr_o) + AW'(1));
endmodule

// File: rtl/stack_engine.sv
module stack_engine
  import stk_pkg::*;
#(
  parameter int              AW       = 16,
  parameter int              DW       = 8,
  parameter logic [AW-1:0]   EMPTY_SP = 16'hFFFE
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic [2*DW-1:0] push_data_i,
  input  logic            pop_i,
  input  logic            sp_load_i,
  input  logic [AW-1:0]   sp_load_val_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [2*DW-1:0] pop_data_o,
  output logic            underflow_o,
  output logic [AW-1:0]   sp_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  output logic            mem_we_o,
  input  logic [DW-1:0]   mem_rdata_i
);
  localparam int STEP = 2;  // bytes per word

  stk_state_e state;
  logic       pop_op, ld, dec, inc, empty;

  stk_seq i_seq (
    .clk_i, .rst_ni,
    .push_i, .pop_i, .load_i(sp_load_i), .empty_i(empty),
    .state_o(state), .pop_op_o(pop_op), .ld_o(ld), .dec_o(dec),
    .inc_o(inc), .uflow_o(underflow_o)
  );

  stk_ptr #(.AW(AW), .EMPTY_SP(EMPTY_SP), .STEP(STEP)) i_ptr (
    .clk_i, .rst_ni,
    .ld_i(ld), .ld_val_i(sp_load_val_i), .dec_i(dec), .inc_i(inc),
    .sp_o, .empty_o(empty)
  );

  stk_dp #(.AW(AW), .DW(DW)) i_dp (
    .clk_i, .rst_ni,
    .state_i(state), .pop_op_i(pop_op), .start_push_i(dec),
    .push_data_i, .sp_i(sp_o), .mem_rdata_i,
    .mem_addr_o, .mem_wdata_o, .mem_we_o, .pop_data_o
  );

  assign busy_o = (state != ST_IDLE);
  assign done_o = (state == ST_DONE);

  p_push_lowers_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !sp_load_i && push_i) |=> sp_o == $past(sp_o) - AW'(STEP));
  p_pop_raises_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_HI && pop_op) |=> sp_o == $past(sp_o) + AW'(STEP));
  p_uflow_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |-> (sp_o == EMPTY_SP && !busy_o && !mem_we_o));
  p_pulses_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, underflow_o, mem_we_o}));
  p_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && sp_load_i) |=> sp_o == $past(sp_load_val_i));
endmodule

// File: tb/test_stack_engine.sv
module test_stack_engine;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        push_i = 1'b0, pop_i = 1'b0, sp_load_i = 1'b0;
  logic [15:0] push_data_i = '0, sp_load_val_i = '0;
  logic        busy_o, done_o, underflow_o, mem_we_o;
  logic [15:0] pop_data_o, sp_o, mem_addr_o;
  logic [7:0]  mem_wdata_o, mem_rdata_i;

  logic [7:0]  mem [0:1023];
  logic [15:0] exp_sp;
  int          checks = 0, errors = 0;
  bit          finished = 1'b0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  stack_engine i_stack_engine (.*);

  assign mem_rdata_i = mem[mem_addr_o[9:0]];
  always @(posedge clk_i) if (mem_we_o) mem[mem_addr_o[9:0]] <= mem_wdata_o;

  function automatic logic [15:0] word_at(input logic [15:0] a);
    logic [15:0] a1;
    a1 = a + 16'd1;
    return {mem[a1[9:0]], mem[a[9:0]]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push_op(input logic [15:0] v, input bit noise, input bit both);
    logic [15:0] ns, n1;
    ns = exp_sp - 16'd2;
    n1 = ns + 16'd1;
    @(negedge clk_i); push_i = 1'b1; push_data_i = v; pop_i = both;
    @(negedge clk_i); push_i = 1'b0; pop_i = noise;
    sp_load_i = noise; sp_load_val_i = 16'h1234;
    chk(sp_o == ns, "R2 sp lowered", {16'h0, sp_o}, {16'h0, ns});
    chk(mem_we_o && mem_addr_o == ns && mem_wdata_o == v[7:0], "R2 low byte write",
        {7'h0, mem_we_o, mem_addr_o, mem_wdata_o}, {8'h1, ns, v[7:0]});
    @(negedge clk_i);
    chk(mem_we_o && mem_addr_o == n1 && mem_wdata_o == v[15:8], "R2 high byte write R8",
        {7'h0, mem_we_o, mem_addr_o, mem_wdata_o}, {8'h1, n1, v[15:8]});
    @(negedge clk_i); pop_i = 1'b0; sp_load_i = 1'b0;
    chk(done_o && !mem_we_o, "R2 done pulse", {30'h0, done_o, mem_we_o}, 32'h2);
    exp_sp = ns;
    @(negedge clk_i);
    chk(!done_o && !busy_o && sp_o == exp_sp, "R6 R7 idle after push, sp untouched",
        {14'h0, done_o, busy_o, sp_o}, {16'h0, exp_sp});
  endtask

  task automatic pop_op();
    logic [15:0] exp_w, a1;
    a1 = exp_sp + 16'd1;
    exp_w = word_at(exp_sp);
    @(negedge clk_i); pop_i = 1'b1;
    @(negedge clk_i); pop_i = 1'b0;
    if (exp_sp == 16'hFFFE) begin
      chk(underflow_o && !busy_o && !mem_we_o && sp_o == 16'hFFFE, "R5 underflow pulse",
          {13'h0, underflow_o, busy_o, mem_we_o, sp_o}, {16'h4, 16'hFFFE});
      @(negedge clk_i);
      chk(!underflow_o && !done_o && sp_o == 16'hFFFE, "R5 single pulse no done",
          {14'h0, underflow_o, done_o, sp_o}, {16'h0, 16'hFFFE});
    end else begin
      chk(!mem_we_o && mem_addr_o == exp_sp, "R3 low byte read",
          {15'h0, mem_we_o, mem_addr_o}, {16'h0, exp_sp});
      @(negedge clk_i);
      chk(!mem_we_o && mem_addr_o == a1, "R3 high byte read R8",
          {15'h0, mem_we_o, mem_addr_o}, {16'h0, a1});
      @(negedge clk_i);
      exp_sp = exp_sp + 16'd2;
      chk(done_o && pop_data_o == exp_w, "R3 R4 popped word",
          {15'h0, done_o, pop_data_o}, {16'h1, exp_w});
      chk(sp_o == exp_sp, "R3 sp raised", {16'h0, sp_o}, {16'h0, exp_sp});
    end
  endtask

  task automatic load_op(input logic [15:0] v, input bit with_req);
    @(negedge clk_i); sp_load_i = 1'b1; sp_load_val_i = v; push_i = with_req; pop_i = with_req;
    @(negedge clk_i); sp_load_i = 1'b0; push_i = 1'b0; pop_i = 1'b0;
    chk(sp_o == v && !busy_o && !mem_we_o, "R9 load", {14'h0, busy_o, mem_we_o, sp_o}, {16'h0, v});
    exp_sp = v;
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 37 + 5);
    exp_sp = 16'hFFFE;
    repeat (3) @(negedge clk_i);
    chk(sp_o == 16'hFFFE && !busy_o && !done_o && !underflow_o && !mem_we_o, "R1 reset",
        {12'h0, busy_o, done_o, underflow_o, mem_we_o, sp_o}, {16'h0, 16'hFFFE});
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(sp_o == 16'hFFFE && !busy_o, "R1 after release", {15'h0, busy_o, sp_o}, {16'h0, 16'hFFFE});

    pop_op();                               // R5 at reset position
    push_op(16'hA1B2, 1'b0, 1'b0);
    push_op(16'hC3D4, 1'b0, 1'b0);
    pop_op();                               // R4 expect C3D4
    pop_op();                               // R4 expect A1B2
    pop_op();                               // R5 again
    push_op(16'h5566, 1'b1, 1'b0);          // R6 noise during push
    push_op(16'h7788, 1'b0, 1'b1);          // R7 push wins
    pop_op();
    pop_op();
    load_op(16'h0001, 1'b0);                // R8 wrap
    push_op(16'hBEEF, 1'b0, 1'b0);          // writes FFFF, 0000
    pop_op();
    load_op(16'h0200, 1'b1);                // R9 overrides request
    load_op(16'hFFFE, 1'b0);

    void'($urandom(32'd20240611));
    for (int n = 0; n < 400; n++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 50)      push_op(16'($urandom), 1'(r % 7 == 0), 1'(r % 11 == 0));
      else if (r < 94) pop_op();
      else             load_op(16'($urandom), 1'(r % 2));
    end
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule